// File: doc/BRIEF.md
# Register-Held Transmit Descriptor Ring

This block holds a small transmit descriptor ring entirely in flip-flops instead of system memory. Each slot has three word-addressed registers: a status word that the hardware fills, a control word carrying the buffer address with the enable and done flags, and a length word. Software prepares a slot, sets its enable flag, and the engine takes it in turn. The engine presents the buffer address and length on a request handshake and waits for a completion pulse with the transmit status. It then writes that status back, retires the slot and moves to the next one.

The engine keeps one current-slot pointer and serves slots strictly in circular order. It never skips a slot that is not enabled, so software fills slots in the same order in which they are sent. Every control word shows the pointer, so software can find the next slot the hardware will service from any of them. Each retired slot raises a one-cycle interrupt pulse. The memory reads, the serialisation and collision handling sit beyond the request/complete interface.

Top module: `txd_ring`

## Requirements
- R1: After an asynchronous reset, every control word reads 0: enable, done, the pointer field and the address are all cleared. `req_valid_o` and `irq_o` are low.
- R2: When the slot at the pointer has enable set, `req_valid_o` rises. `req_addr_o` carries the slot's address with bits 5:0 at zero, and `req_len_o` carries the slot's length. All three hold steady until `req_ready_i` is sampled high.
- R3: A `cpl_valid_i` pulse while a request is outstanding retires the slot in one edge. The slot's status word takes `cpl_status_i`, its done bit sets, its enable bit clears, and the pointer advances by one.
- R4: Slots are served in ascending order and the pointer wraps from the last slot to slot 0.
- R5: While the slot at the pointer has enable at 0, no request is issued, even if later slots are enabled.
- R6: The control word reads as follows: bit 0 is enable, bit 1 is done, bits 3:2 hold the current pointer (the same value in every slot), bits 5:4 read 0, and bits 31:6 hold the written address. Written values in bits 5:2 are dropped.
- R7: A software write to the control word clears done when bit 1 is 0 and leaves done unchanged when bit 1 is 1. Software can never set done.
- R8: The status word ignores software writes. Only bits 13:0 and bit 31 are stored, and all other bits read 0. The stored bits are: bit 0 aborted, 1 jabber, 2 no carrier, 3 carrier lost, 4 excess deferral, 5 late-collision abort, 6 excess collisions, 7 underrun, 8 deferred, 9 late collision, 13:10 collision count, and 31 retry.
- R9: The length word stores `LEN_W` bits, and the bits above them read 0.
- R10: `irq_o` is high for exactly one cycle per retired slot, in the cycle in which that slot's done bit first reads 1.
- R11: A `cpl_valid_i` pulse with no request outstanding changes no status word, no done bit and no pointer, and raises no interrupt.
- R12: Slot n sits at byte offset 16*n, with status at +0, control at +4 and length at +8. The word at +12 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | $clog2(NUM_SLOTS)+4 | Register byte address; bits 1:0 ignored |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| req_valid_o | output | 1 | Buffer fetch request valid |
| req_ready_i | input | 1 | Fetch request accepted |
| req_addr_o | output | 32 | Buffer address of the request |
| req_len_o | output | LEN_W | Frame length of the request |
| cpl_valid_i | input | 1 | Frame completion pulse |
| cpl_status_i | input | 32 | Transmit status delivered with the completion |
| irq_o | output | 1 | One-cycle pulse per retired slot |

## Verification
The bench builds the block with four slots and a 14-bit length. With four slots the two-bit pointer field is fully used, and the wrap from slot 3 back to slot 0 is reached within a handful of frames. With a 14-bit length, the zeroed upper bits of the length word can be seen from an all-ones write. The scenarios cover a stall on a disabled slot while later slots wait enabled, a completion pulse with no request outstanding, and the masking of undefined status bits.

// File: rtl/txd_ring_pkg.sv
package txd_ring_pkg;
  // defined transmit status bits: 13:0 and 31
  localparam logic [31:0] STAT_MASK = 32'h8000_3FFF;
  // word select within a 16-byte slot
  localparam logic [1:0] W_STAT = 2'd0;
  localparam logic [1:0] W_CTRL = 2'd1;
  localparam logic [1:0] W_LEN  = 2'd2;
  localparam int BUF_LSB = 6;
  localparam int BUF_W   = 32 - BUF_LSB;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_REQ,
    ENG_WAIT
  } eng_state_e;
endpackage

// File: rtl/txd_slot.sv
module txd_slot
  import txd_ring_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ctrl_i,
  input  logic             wr_len_i,
  input  logic [31:0]      wdata_i,
  input  logic             cpl_i,
  input  logic [31:0]      cpl_status_i,
  output logic             en_o,
  output logic             done_o,
  output logic [BUF_W-1:0] addr_o,
  output logic [LEN_W-1:0] len_o,
  output logic [31:0]      status_o
);
  logic unused_wbits;
  assign unused_wbits = ^wdata_i[BUF_LSB-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o     <= 1'b0;
      done_o   <= 1'b0;
      addr_o   <= '0;
      len_o    <= '0;
      status_o <= '0;
    end else begin
      if (wr_ctrl_i) begin
        en_o   <= wdata_i[0];
        done_o <= done_o & wdata_i[1];  // software may only clear done
        addr_o <= wdata_i[31:BUF_LSB];
      end
      if (wr_len_i) len_o <= wdata_i[LEN_W-1:0];
      // hardware retire wins over a same-cycle software write
      if (cpl_i) begin
        en_o     <= 1'b0;
        done_o   <= 1'b1;
        status_o <= cpl_status_i & STAT_MASK;
      end
    end
  end
endmodule

// File: rtl/txd_engine.sv
module txd_engine
  import txd_ring_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int LEN_W     = 14,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] slot_en_i,
  input  logic [BUF_W-1:0]     cur_addr_i,
  input  logic [LEN_W-1:0]     cur_len_i,
  input  logic                 req_ready_i,
  input  logic                 cpl_valid_i,
  output logic [IDX_W-1:0]     cur_idx_o,
  output logic                 req_valid_o,
  output logic [31:0]          req_addr_o,
  output logic [LEN_W-1:0]     req_len_o,
  output logic                 cpl_fire_o,
  output logic                 irq_o
);
  eng_state_e state_q;

  assign req_valid_o = (state_q == ENG_REQ);
  assign cpl_fire_o  = (state_q == ENG_WAIT) && cpl_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ENG_IDLE;
      cur_idx_o  <= '0;
      req_addr_o <= '0;
      req_len_o  <= '0;
      irq_o      <= 1'b0;
    end else begin
      irq_o <= cpl_fire_o;
      unique case (state_q)
        ENG_IDLE: if (slot_en_i[cur_idx_o]) begin
          state_q    <= ENG_REQ;
          req_addr_o <= {cur_addr_i, {BUF_LSB{1'b0}}};
          req_len_o  <= cur_len_i;
        end
        ENG_REQ:  if (req_ready_i) state_q <= ENG_WAIT;
        ENG_WAIT: if (cpl_valid_i) begin
          state_q   <= ENG_IDLE;
          cur_idx_o <= cur_idx_o + 1'b1;  // power-of-two ring wraps
        end
        default:  state_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txd_ring.sv
module txd_ring
  import txd_ring_pkg::*;
#(
  parameter int NUM_SLOTS = 4,  // power of two, 2 or 4 (index field is 2 bits)
  parameter int LEN_W     = 14,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int AW       = IDX_W + 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic [31:0]      req_addr_o,
  output logic [LEN_W-1:0] req_len_o,
  input  logic             cpl_valid_i,
  input  logic [31:0]      cpl_status_i,
  output logic             irq_o
);
  logic [IDX_W-1:0]     slot_sel;
  logic [1:0]           word_sel;
  logic [IDX_W-1:0]     cur_idx;
  logic                 cpl_fire;
  logic [NUM_SLOTS-1:0] slot_en, slot_done;
  logic [BUF_W-1:0]     slot_addr [NUM_SLOTS];
  logic [LEN_W-1:0]     slot_len  [NUM_SLOTS];
  logic [31:0]          slot_stat [NUM_SLOTS];
  logic                 unused_alo;

  assign slot_sel   = reg_addr_i[AW-1:4];
  assign word_sel   = reg_addr_i[3:2];
  assign unused_alo = ^reg_addr_i[1:0];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    txd_slot #(.LEN_W(LEN_W)) u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_ctrl_i    (reg_we_i && slot_sel == IDX_W'(i) && word_sel == W_CTRL),
      .wr_len_i     (reg_we_i && slot_sel == IDX_W'(i) && word_sel == W_LEN),
      .wdata_i      (reg_wdata_i),
      .cpl_i        (cpl_fire && cur_idx == IDX_W'(i)),
      .cpl_status_i (cpl_status_i),
      .en_o         (slot_en[i]),
      .done_o       (slot_done[i]),
      .addr_o       (slot_addr[i]),
      .len_o        (slot_len[i]),
      .status_o     (slot_stat[i])
    );
  end

  txd_engine #(.NUM_SLOTS(NUM_SLOTS), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slot_en_i   (slot_en),
    .cur_addr_i  (slot_addr[cur_idx]),
    .cur_len_i   (slot_len[cur_idx]),
    .req_ready_i (req_ready_i),
    .cpl_valid_i (cpl_valid_i),
    .cur_idx_o   (cur_idx),
    .req_valid_o (req_valid_o),
    .req_addr_o  (req_addr_o),
    .req_len_o   (req_len_o),
    .cpl_fire_o  (cpl_fire),
    .irq_o       (irq_o)
  );

  always_comb begin
    unique case (word_sel)
      W_STAT:  reg_rdata_o = slot_stat[slot_sel];
      W_CTRL:  reg_rdata_o = {slot_addr[slot_sel], 2'b00, 2'(cur_idx),
                              slot_done[slot_sel], slot_en[slot_sel]};
      W_LEN:   reg_rdata_o = 32'(slot_len[slot_sel]);
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/txd_ring_chk.sv
module txd_ring_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int LEN_W     = 14,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_o,
  input logic             req_ready_i,
  input logic [31:0]      req_addr_o,
  input logic [LEN_W-1:0] req_len_o,
  input logic             cpl_valid_i,
  input logic             irq_o,
  input logic [IDX_W-1:0] cur_idx_i
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_len_o)); // R2
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(cpl_valid_i) && !req_valid_o); // R3
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_idx_i != $past(cur_idx_i)) |-> irq_o && (cur_idx_i == IDX_W'($past(cur_idx_i) + 1'b1))); // R4
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R10
endmodule

bind txd_ring txd_ring_chk #(.NUM_SLOTS(NUM_SLOTS), .LEN_W(LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_addr_o  (req_addr_o),
  .req_len_o   (req_len_o),
  .cpl_valid_i (cpl_valid_i),
  .irq_o       (irq_o),
  .cur_idx_i   (cur_idx)
);

// File: tb/txd_ring_tb.sv
module txd_ring_tb;
  localparam int NS = 4;
  localparam int LW = 14;

  typedef struct packed {
    logic [31:0] addr;
    logic [LW-1:0] len;
    logic [31:0] st;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic req_valid, req_ready = 1'b0;
  logic [31:0] req_addr;
  logic [LW-1:0] req_len;
  logic cpl_valid = 1'b0;
  logic [31:0] cpl_status = '0;
  logic irq;

  item_t exp_q[$];
  int ncmp = 0, nerr = 0, irq_cnt = 0;
  int stray_req = 0, stray_done = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  txd_ring #(.NUM_SLOTS(NS), .LEN_W(LW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .req_valid_o(req_valid),
    .req_ready_i(req_ready), .req_addr_o(req_addr), .req_len_o(req_len),
    .cpl_valid_i(cpl_valid), .cpl_status_i(cpl_status), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
      $finish;
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic chk_rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1 check(tag, rdata, exp);
  endtask

  task automatic wait_irq(input int n);
    while (irq_cnt < n) @(negedge clk);
  endtask

  // interrupt monitor
  always @(negedge clk) if (rst_n && irq) irq_cnt++;

  // scoreboard monitor and fetch/complete responder
  initial begin : responder
    item_t it;
    logic [31:0] a0;
    forever begin
      @(negedge clk);
      if (stray_req != stray_done) begin
        cpl_valid = 1'b1; cpl_status = 32'hFFFF_FFFF;
        @(negedge clk);
        cpl_valid = 1'b0;
        stray_done++;
      end else if (req_valid) begin
        a0 = req_addr;
        @(negedge clk);
        @(negedge clk);
        check("R2 valid held", 32'(req_valid), 32'd1);
        check("R2 addr held", req_addr, a0);
        if (exp_q.size() == 0) begin
          check("R4 unexpected request", req_addr, 32'hDEAD_DEAD);
          it = '0;
        end else begin
          it = exp_q.pop_front();
          check("R2 R4 request addr", req_addr, it.addr);
          check("R2 request len", 32'(req_len), 32'(it.len));
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        @(negedge clk);
        cpl_valid = 1'b1; cpl_status = it.st;
        @(negedge clk);
        cpl_valid = 1'b0;
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check("watchdog expired", 32'd1, 32'd0);
    report();
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < NS; i++) chk_rd("R1 ctrl after reset", 6'(16*i + 4), 32'h0);
    check("R1 req_valid low", 32'(req_valid), 32'd0);
    check("R1 irq low", 32'(irq), 32'd0);

    // R6 control field layout, R9 length width, R8 status write ignored, R12 map
    wr(6'h14, 32'hFFFF_FFFC);
    chk_rd("R6 ctrl bits 5:2 dropped", 6'h14, 32'hFFFF_FFC0);
    wr(6'h18, 32'hFFFF_FFFF);
    chk_rd("R9 length width", 6'h18, 32'h0000_3FFF);
    wr(6'h10, 32'hFFFF_FFFF);
    chk_rd("R8 status ignores writes", 6'h10, 32'h0);
    wr(6'h1C, 32'h1234_5678);
    chk_rd("R12 unused word reads 0", 6'h1C, 32'h0);
    chk_rd("R12 unused write no effect", 6'h18, 32'h0000_3FFF);

    wr(6'h14, 32'h2000_0000); wr(6'h18, 32'd200);
    wr(6'h24, 32'h3000_0040); wr(6'h28, 32'd60);
    wr(6'h34, 32'h4000_0080); wr(6'h38, 32'd1500);

    // single frame from slot 0
    wr(6'h08, 32'd100);
    exp_q.push_back('{addr: 32'h1000_0040, len: LW'(100), st: 32'h8010_3C81});
    wr(6'h04, 32'h1000_0041);
    wait_irq(1);
    chk_rd("R3 slot0 done set, enable clear, ptr 1", 6'h04, 32'h1000_0046);
    chk_rd("R8 status masked", 6'h00, 32'h8000_3C81);
    chk_rd("R6 pointer visible in slot1", 6'h14, 32'h2000_0004);
    check("R10 one irq", 32'(irq_cnt), 32'd1);

    // R7 done semantics
    wr(6'h24, 32'h3000_0042);
    chk_rd("R7 writing 1 does not set done", 6'h24, 32'h3000_0044);
    wr(6'h04, 32'h1000_0040);
    chk_rd("R7 writing 0 clears done", 6'h04, 32'h1000_0044);

    // R5 stall on disabled current slot
    wr(6'h24, 32'h3000_0041);
    wr(6'h34, 32'h4000_0081);
    repeat (10) @(negedge clk);
    check("R5 no request while current slot idle", 32'(req_valid), 32'd0);
    chk_rd("R5 later slot still pending", 6'h24, 32'h3000_0045);

    // R4 ordered service 1,2,3 and wrap
    exp_q.push_back('{addr: 32'h2000_0000, len: LW'(200),  st: 32'h0000_0400});
    exp_q.push_back('{addr: 32'h3000_0040, len: LW'(60),   st: 32'h0000_0100});
    exp_q.push_back('{addr: 32'h4000_0080, len: LW'(1500), st: 32'h0000_0000});
    wr(6'h14, 32'h2000_0001);
    wait_irq(4);
    chk_rd("R4 slot3 done, pointer wrapped to 0", 6'h34, 32'h4000_0082);
    chk_rd("R3 slot1 status", 6'h10, 32'h0000_0400);
    check("R4 all expected requests served", 32'(exp_q.size()), 32'd0);
    exp_q.push_back('{addr: 32'h1000_0040, len: LW'(100), st: 32'h0000_0001});
    wr(6'h04, 32'h1000_0041);
    wait_irq(5);
    chk_rd("R4 slot0 served after wrap", 6'h04, 32'h1000_0046);
    chk_rd("R3 slot0 new status", 6'h00, 32'h0000_0001);
    check("R10 irq count", 32'(irq_cnt), 32'd5);

    // R11 stray completion
    stray_req++;
    repeat (6) @(negedge clk);
    chk_rd("R11 status unchanged", 6'h10, 32'h0000_0400);
    chk_rd("R11 ctrl and pointer unchanged", 6'h14, 32'h2000_0006);
    check("R11 no irq", 32'(irq_cnt), 32'd5);

    // R1 reset clears control bits
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    chk_rd("R1 slot0 ctrl after reset", 6'h04, 32'h0);
    chk_rd("R1 slot3 ctrl after reset", 6'h34, 32'h0);
    report();
  end
endmodule